// File: doc/BRIEF.md
# Bias Power Sequencer

This block brings up the bias rails of a display panel supply in a fixed order and shuts them down together if anything goes wrong. A delay timer produces six back-to-back ramps of equal length, each `RAMP_LEN` clock cycles long. The reference, the boost soft-start, the negative rail and the positive rail are switched on at set ramp boundaries. The boost and rail undervoltage flags are sampled only at the ends of chosen ramps. After the sixth ramp the gate-slice switch output is released to its control pin.

Any fault latches every enable off and raises a fault status. Faults come from three sources: over-temperature at any time, a failed rail check, or a sequence that has not finished within `TIMEOUT_RAMPS` ramp lengths. The latch clears only when the enable input goes low or the supply-valid flag drops. The supply-valid flag is built from two comparator inputs with hysteresis. Analog slopes and comparators lie outside the block and are seen only as digital flags.

Top module: `bias_power_sequencer`

## Requirements
- R1: An internal supply-valid flag sets when `sup_rise_ok` is 1, holds while `sup_fall_ok` is 1, and clears one clock after `sup_fall_ok` is 0 with `sup_rise_ok` 0. A sequence runs only while supply-valid and `enable` are both 1; otherwise the block sits idle with every output 0.
- R2: The sequence is six ramps of `RAMP_LEN` clocks each. Ramp 1 begins on the clock after the block leaves idle. Completion is registered on the clock after the last cycle of ramp 6.
- R3: `ref_en` rises on the first clock of ramp 2, which marks the end of ramp 1.
- R4: `boost_en` rises on the first clock of ramp 3. If `uv_boost` is 1 on the last clock of ramp 3, a fault latches.
- R5: `neg_en` rises on the first clock of ramp 4.
- R6: `pos_en` rises on the first clock of ramp 6. If `uv_pos` or `uv_neg` is 1 on the last clock of ramp 6, a fault latches and the sequence does not complete.
- R7: A latched fault drives `fault_latched` to 1, all four enables to 0 and `slice_sel` to ground. It holds through any later input change until `enable` is 0 or supply-valid drops. Either of these returns the block to idle with `fault_latched` 0.
- R8: `over_temp` at 1 while the block is active latches a fault on the next clock, in any phase, including ramp 1 and after completion.
- R9: `slice_sel` uses the encoding 0 = ground, 1 = low level, 2 = high level. It is 0 whenever the sequence has not completed.
- R10: On the first completed clock `slice_sel` is 1. From then on it follows `slice_ctl` with one clock of delay: 0 selects 1 (low) and 1 selects 2 (high).
- R11: If the sequence has not completed `TIMEOUT_RAMPS * RAMP_LEN` clocks after ramp 1 begins, a fault latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_rise_ok | input | 1 | Supply above the rising lockout threshold |
| sup_fall_ok | input | 1 | Supply above the falling lockout threshold |
| enable | input | 1 | Sequence enable; low clears a latched fault |
| over_temp | input | 1 | Over-temperature flag |
| uv_boost | input | 1 | Boost output undervoltage flag |
| uv_pos | input | 1 | Positive rail undervoltage flag |
| uv_neg | input | 1 | Negative rail undervoltage flag |
| slice_ctl | input | 1 | Gate-slice control input |
| ref_en | output | 1 | Reference enable |
| boost_en | output | 1 | Boost soft-start enable |
| neg_en | output | 1 | Negative rail enable |
| pos_en | output | 1 | Positive rail enable |
| fault_latched | output | 1 | Fault latch status |
| slice_sel | output | 2 | Slice switch select: 0 ground, 1 low, 2 high |

## Verification
A ramp counter or ramp index that slips by one moves an enable edge by a whole ramp or by one clock. The bench therefore samples each enable on the clock before and the clock of its expected rise. If a check is sampled on the wrong ramp, a fault appears one ramp early or late, or never appears; `fault_latched` is probed on the exact clock after the check cycle. A broken latch or a broken hysteresis register shows up within two clocks, as an enable or fault that clears, or stays set, when an input is removed. An error in the slice handover shows on the first one or two completed clocks.

// File: rtl/bps_pkg.sv
package bps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAMP  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } seq_st_e;

    typedef enum logic [1:0] {
        SL_GND  = 2'd0,
        SL_LOW  = 2'd1,
        SL_HIGH = 2'd2
    } slice_sel_e;

    localparam int IDX_W = 3;
    localparam logic [IDX_W-1:0] RAMP_FIRST = 3'd1;
    localparam logic [IDX_W-1:0] RAMP_REF   = 3'd1;
    localparam logic [IDX_W-1:0] RAMP_BOOST = 3'd3;
    localparam logic [IDX_W-1:0] RAMP_NEG   = 3'd4;
    localparam logic [IDX_W-1:0] RAMP_LAST  = 3'd6;

endpackage

// File: rtl/bps_supply_hyst.sv
module bps_supply_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_ok,
    input  logic fall_ok,
    output logic valid_o
);
    logic valid_d, valid_q;

    always_comb begin
        valid_d = valid_q;
        if (rise_ok)
            valid_d = 1'b1;
        else if (!fall_ok)
            valid_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_d;
    end

    assign valid_o = valid_q;

    // R1
    hyst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && fall_ok |=> valid_q);

endmodule

// File: rtl/bps_ramp_timer.sv
module bps_ramp_timer
    import bps_pkg::*;
#(
    parameter int RAMP_LEN = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [IDX_W-1:0] idx_o,
    output logic             ramp_end_o
);
    localparam int CNT_W = (RAMP_LEN > 1) ? $clog2(RAMP_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RAMP_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (!run) begin
            d.cnt = '0;
            d.idx = RAMP_FIRST;
        end else if (q.cnt == CNT_LAST) begin
            d.cnt = '0;
            d.idx = (q.idx == RAMP_LAST) ? RAMP_FIRST : q.idx + IDX_W'(1);
        end else begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, idx: RAMP_FIRST};
        else        q <= d;
    end

    assign idx_o      = q.idx;
    assign ramp_end_o = run && (q.cnt == CNT_LAST);

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.idx >= RAMP_FIRST) && (q.idx <= RAMP_LAST));

    // R2
    idx_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !ramp_end_o |=> $stable(q.idx));

endmodule

// File: rtl/bps_timeout.sv
module bps_timeout #(
    parameter int LIMIT = 10240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired_o
);
    localparam int TO_W = $clog2(LIMIT + 1);
    localparam logic [TO_W-1:0] TO_LAST = TO_W'(LIMIT - 1);

    logic [TO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q != TO_LAST)
            cnt_d = cnt_q + TO_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run && (cnt_q == TO_LAST);

endmodule

// File: rtl/bias_power_sequencer.sv
module bias_power_sequencer
    import bps_pkg::*;
#(
    parameter int RAMP_LEN      = 1024,
    parameter int TIMEOUT_RAMPS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_rise_ok,
    input  logic       sup_fall_ok,
    input  logic       enable,
    input  logic       over_temp,
    input  logic       uv_boost,
    input  logic       uv_pos,
    input  logic       uv_neg,
    input  logic       slice_ctl,
    output logic       ref_en,
    output logic       boost_en,
    output logic       neg_en,
    output logic       pos_en,
    output logic       fault_latched,
    output logic [1:0] slice_sel
);
    localparam int TO_LIMIT = TIMEOUT_RAMPS * RAMP_LEN;

    typedef struct packed {
        seq_st_e    st;
        logic       ref_en;
        logic       boost_en;
        logic       neg_en;
        logic       pos_en;
        logic       fault;
        slice_sel_e slice;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{st: ST_IDLE, ref_en: 1'b0, boost_en: 1'b0,
                                  neg_en: 1'b0, pos_en: 1'b0, fault: 1'b0,
                                  slice: SL_GND};
    localparam ctl_t CTL_FAULT = '{st: ST_FAULT, ref_en: 1'b0, boost_en: 1'b0,
                                   neg_en: 1'b0, pos_en: 1'b0, fault: 1'b1,
                                   slice: SL_GND};

    ctl_t d, q;

    logic             sup_valid;
    logic             active;
    logic             ramp_run;
    logic [IDX_W-1:0] ramp_idx;
    logic [IDX_W-1:0] idx_next;
    logic             ramp_end;
    logic             to_expired;

    bps_supply_hyst u_hyst (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_ok (sup_rise_ok),
        .fall_ok (sup_fall_ok),
        .valid_o (sup_valid)
    );

    assign ramp_run = (q.st == ST_RAMP);

    bps_ramp_timer #(.RAMP_LEN(RAMP_LEN)) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ramp_run),
        .idx_o      (ramp_idx),
        .ramp_end_o (ramp_end)
    );

    bps_timeout #(.LIMIT(TO_LIMIT)) u_timeout (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ramp_run),
        .expired_o (to_expired)
    );

    assign active = sup_valid && enable;

    always_comb begin
        d        = q;
        idx_next = ramp_idx + IDX_W'(1);
        if (!active) begin
            d = CTL_IDLE;
        end else if (over_temp) begin
            d = CTL_FAULT;
        end else begin
            unique case (q.st)
                ST_IDLE: d.st = ST_RAMP;
                ST_RAMP: begin
                    if (ramp_end) begin
                        if (idx_next == RAMP_BOOST) d.boost_en = 1'b1;
                        if (idx_next == RAMP_NEG)   d.neg_en   = 1'b1;
                        if (idx_next == RAMP_LAST)  d.pos_en   = 1'b1;
                        if (ramp_idx == RAMP_REF)   d.ref_en   = 1'b1;
                        if (ramp_idx == RAMP_BOOST && uv_boost)
                            d = CTL_FAULT;
                        if (ramp_idx == RAMP_LAST) begin
                            if (uv_pos || uv_neg) begin
                                d = CTL_FAULT;
                            end else begin
                                d.st    = ST_DONE;
                                d.slice = SL_LOW;
                            end
                        end
                    end
                    if (to_expired) d = CTL_FAULT;
                end
                ST_DONE:  d.slice = slice_ctl ? SL_HIGH : SL_LOW;
                ST_FAULT: d = CTL_FAULT;
                default:  d = CTL_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_IDLE;
        else        q <= d;
    end

    assign ref_en        = q.ref_en;
    assign boost_en      = q.boost_en;
    assign neg_en        = q.neg_en;
    assign pos_en        = q.pos_en;
    assign fault_latched = q.fault;
    assign slice_sel     = q.slice;

    // R6
    rail_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_en |-> (neg_en && boost_en && ref_en));

    // R7
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> !(ref_en || boost_en || neg_en || pos_en) && (slice_sel == 2'd0));

    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched && sup_valid && enable |=> fault_latched);

    // R8
    over_temp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp && sup_valid && enable |=> fault_latched);

    // R9
    slice_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_DONE) |-> (slice_sel == 2'd0));

    // R10
    slice_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DONE) && $past(q.st == ST_DONE)
        |-> (slice_sel == ($past(slice_ctl) ? 2'd2 : 2'd1)));

endmodule

// File: tb/bias_power_sequencer_tb.sv
module bias_power_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int L = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_rise_ok = 1'b0, sup_fall_ok = 1'b0, enable = 1'b1, over_temp = 1'b0;
    logic uv_boost = 1'b0, uv_pos = 1'b0, uv_neg = 1'b0, slice_ctl = 1'b0;
    logic ref_en, boost_en, neg_en, pos_en, fault_latched;
    logic [1:0] slice_sel;
    logic t_ref, t_boost, t_neg, t_pos, t_fault;
    logic [1:0] t_slice;

    int n_run = 0;
    int n_fail = 0;
    int m_now = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bias_power_sequencer #(.RAMP_LEN(L), .TIMEOUT_RAMPS(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .sup_rise_ok(sup_rise_ok), .sup_fall_ok(sup_fall_ok),
        .enable(enable), .over_temp(over_temp), .uv_boost(uv_boost), .uv_pos(uv_pos),
        .uv_neg(uv_neg), .slice_ctl(slice_ctl), .ref_en(ref_en), .boost_en(boost_en),
        .neg_en(neg_en), .pos_en(pos_en), .fault_latched(fault_latched), .slice_sel(slice_sel));

    bias_power_sequencer #(.RAMP_LEN(L), .TIMEOUT_RAMPS(5)) u_dut_to (
        .clk(clk), .rst_n(rst_n), .sup_rise_ok(sup_rise_ok), .sup_fall_ok(sup_fall_ok),
        .enable(enable), .over_temp(over_temp), .uv_boost(uv_boost), .uv_pos(uv_pos),
        .uv_neg(uv_neg), .slice_ctl(slice_ctl), .ref_en(t_ref), .boost_en(t_boost),
        .neg_en(t_neg), .pos_en(t_pos), .fault_latched(t_fault), .slice_sel(t_slice));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic adv(input int target);
        while (m_now < target) begin
            @(negedge clk);
            m_now++;
        end
    endtask

    task automatic supply_up();
        sup_rise_ok = 1'b1;
        sup_fall_ok = 1'b1;
        m_now = 0;
    endtask

    task automatic quiesce();
        sup_rise_ok = 1'b0; sup_fall_ok = 1'b0; enable = 1'b1; over_temp = 1'b0;
        uv_boost = 1'b0; uv_pos = 1'b0; uv_neg = 1'b0; slice_ctl = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R9", "reset slice", slice_sel, 0);
        chk("R7", "reset fault", fault_latched, 0);
        chk("R1", "reset enables", {ref_en, boost_en, neg_en, pos_en}, 0);
    endtask

    task automatic t_enable_gate();
        enable = 1'b0;
        supply_up();
        adv(L + 3);
        chk("R1", "enable low keeps ref off", ref_en, 0);
        quiesce();
    endtask

    task automatic t_nominal();
        slice_ctl = 1'b1;
        supply_up();
        adv(2);
        chk("R2", "idle then ramp, no enables", {ref_en, boost_en}, 0);
        adv(L + 1);      chk("R3", "ref before ramp2", ref_en, 0);
        adv(L + 2);      chk("R3", "ref at ramp2", ref_en, 1);
        adv(2*L + 1);    chk("R4", "boost before ramp3", boost_en, 0);
        adv(2*L + 2);    chk("R4", "boost at ramp3", boost_en, 1);
        adv(3*L);        chk("R9", "slice during ramps", slice_sel, 0);
        adv(3*L + 1);    chk("R5", "neg before ramp4", neg_en, 0);
        adv(3*L + 2);    chk("R5", "neg at ramp4", neg_en, 1);
        adv(5*L + 1);
        chk("R6", "pos before ramp6", pos_en, 0);
        chk("R11", "timeout not yet", t_fault, 0);
        adv(5*L + 2);
        chk("R6", "pos at ramp6", pos_en, 1);
        chk("R11", "short timeout fires", t_fault, 1);
        chk("R11", "short timeout enables off", t_pos, 0);
        chk("R11", "long timeout silent", fault_latched, 0);
        adv(6*L + 1);    chk("R9", "slice before done", slice_sel, 0);
        adv(6*L + 2);    chk("R10", "first done slice low", slice_sel, 1);
        adv(6*L + 3);    chk("R10", "slice follows ctl high", slice_sel, 2);
        slice_ctl = 1'b0;
        adv(6*L + 4);    chk("R10", "slice follows ctl low", slice_sel, 1);
        sup_rise_ok = 1'b0;
        adv(6*L + 8);    chk("R1", "hysteresis holds", pos_en, 1);
        sup_fall_ok = 1'b0;
        adv(6*L + 9);    chk("R1", "one clock after fall", pos_en, 1);
        adv(6*L + 10);
        chk("R1", "supply loss idles", {ref_en, boost_en, neg_en, pos_en}, 0);
        chk("R9", "supply loss slice", slice_sel, 0);
        quiesce();
    endtask

    task automatic t_boost_fault();
        uv_boost = 1'b1;
        supply_up();
        adv(3*L + 1);
        chk("R4", "no fault before boost check", fault_latched, 0);
        adv(3*L + 2);
        chk("R4", "boost uv latches fault", fault_latched, 1);
        chk("R7", "fault clears enables", {ref_en, boost_en, neg_en, pos_en}, 0);
        uv_boost = 1'b0;
        adv(5*L);
        chk("R7", "fault stays latched", fault_latched, 1);
        enable = 1'b0;
        m_now = 0;
        adv(1);
        chk("R7", "enable low clears fault", fault_latched, 0);
        enable = 1'b1;
        m_now = 0;
        adv(L);          chk("R7", "restart ref not yet", ref_en, 0);
        adv(L + 1);      chk("R7", "restart ref on", ref_en, 1);
        quiesce();
    endtask

    task automatic t_rail_fault(input bit use_neg);
        uv_neg = use_neg;
        uv_pos = !use_neg;
        supply_up();
        adv(6*L + 1);
        chk("R6", "no fault before rail check", fault_latched, 0);
        adv(6*L + 2);
        chk("R6", "rail uv latches fault", fault_latched, 1);
        chk("R6", "rail fault slice ground", slice_sel, 0);
        quiesce();
        chk("R7", "supply loss clears fault", fault_latched, 0);
    endtask

    task automatic t_over_temp();
        supply_up();
        adv(3);
        over_temp = 1'b1;
        adv(4);
        chk("R8", "over-temp in ramp1", fault_latched, 1);
        quiesce();
        slice_ctl = 1'b1;
        supply_up();
        adv(6*L + 3);
        chk("R10", "done before over-temp", slice_sel, 2);
        over_temp = 1'b1;
        adv(6*L + 4);
        chk("R8", "over-temp after done", fault_latched, 1);
        chk("R8", "over-temp slice ground", slice_sel, 0);
        over_temp = 1'b0;
        adv(6*L + 8);
        chk("R7", "latched after over-temp clears", fault_latched, 1);
        quiesce();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_enable_gate();
        t_nominal();
        t_boost_fault();
        t_rail_fault(1'b1);
        t_rail_fault(1'b0);
        t_over_temp();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule